// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and a bus-cycle engine that drives a 128K x 8 parallel NOR flash divided into eight 16 KB sectors. The host hands it one operation at a time (program one byte, erase one sector, full or short reset, read the manufacturer code, read the device code). The block turns the operation into the series of single write and read cycles that the flash expects. It hands those cycles one by one to the bus-cycle engine over a request/acknowledge pair.

For program and erase, the block then watches the flash's progress by reading status back from the operation's own address. It reports success once status bit 7 shows the expected final value. It reports failure when the flash raises its time-limit flag (bit 5) and a confirming re-read still shows no completion, or when a poll budget runs out. After any failure it writes the short reset code, so that the flash returns to plain read mode before the host sees the result.

Top module: `flash_cmd_seq`

## Requirements
- R1: An operation is taken when `op_valid` is high while `op_ready` is high. `op_ready` stays low until the operation ends. `op_done` is a one-cycle pulse, after which `op_ready` is high again. Opcodes: 0 program, 1 sector erase, 2 full reset, 3 short reset, 4 manufacturer code, 5 device code.
- R2: Every opcode except short reset opens with a write of 0xAA to 0x05555, then a write of 0x55 to 0x02AAA. All constant command addresses have bit 16 low.
- R3: Program continues with 0xA0 to 0x05555, then the data byte to `op_addr`, then status polling.
- R4: Sector erase continues with 0x80 to 0x05555, 0xAA to 0x05555, 0x55 to 0x02AAA, then 0x30 to the sector base (`op_addr` bits 16..14 kept, bits 13..0 zero), then status polling.
- R5: Full reset continues with 0xF0 to 0x05555. Short reset is a single write of 0xF0 to `op_addr`. Both end with pass=1 and result 0x00 and issue no read.
- R6: The manufacturer and device opcodes continue with 0x90 to 0x05555, then read address 0x00000 (manufacturer) or 0x00001 (device), then write 0xF0 to `op_addr`. The result is the byte read. Pass is 1 only when that byte is 0x01 (manufacturer) or 0x20 (device).
- R7: Polling reads come from `op_addr`. When read bit 7 equals the expected value (data bit 7 for program, 1 for erase), the operation ends with pass=1 and the read byte as result.
- R8: When a poll shows bit 7 not matching and bit 5 set, exactly one more read follows. If that read matches, the result is a pass. Otherwise it is a failure.
- R9: Every polling failure writes 0xF0 to `op_addr` before `op_done`. It then reports pass=0 with the last status byte as result.
- R10: After MAX_POLLS (default 16) non-matching poll reads with bit 5 clear, the operation fails as in R9.
- R11: `bus_req` with its address, data and direction stays steady until the cycle in which `bus_ack` is high. It drops for at least one cycle before the next request. `bus_req` is never high while `op_ready` is high.
- R12: Opcodes 6 and 7 end at once with pass=0, result 0x00 and no bus cycle.
- R13: After reset `op_ready` is 1, while `op_done` and `bus_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | Operation selector (see R1) |
| op_addr | input | 17 | Target byte or sector address |
| op_data | input | 8 | Byte to program |
| op_ready | output | 1 | Idle and able to take an operation |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| op_pass | output | 1 | Outcome, valid with op_done and held after |
| op_result | output | 8 | Status or ID byte, valid with op_done |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 17 | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Bus cycle finished this clock |
| bus_rdata | input | 8 | Read data, valid with bus_ack |

## Verification
The bench aims at the polling corner cases. It plays a status that shows the time-limit flag and then completes, which a design without the re-read would report as a failure. It also plays a flag followed by a still-wrong bit 7, which a design that kept polling would never end. It runs a budget of plain non-matching reads, where an off-by-one counter shows up as one read too many or too few. It checks the sector base on an erase whose address has low bits set, because a design passing `op_addr` through unmasked would erase at the wrong address. It also checks that the recovery write and the unknown opcodes produce exactly the cycles listed and no more.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int FL_AW = 17;
  localparam int FL_DW = 8;

  localparam logic [2:0] OPC_PROG      = 3'd0;
  localparam logic [2:0] OPC_ERASE     = 3'd1;
  localparam logic [2:0] OPC_RST_FULL  = 3'd2;
  localparam logic [2:0] OPC_RST_SHORT = 3'd3;
  localparam logic [2:0] OPC_ID_MFR    = 3'd4;
  localparam logic [2:0] OPC_ID_DEV    = 3'd5;

  localparam logic [FL_AW-1:0] KEY_ADDR_A = 17'h05555;
  localparam logic [FL_AW-1:0] KEY_ADDR_B = 17'h02AAA;
  localparam logic [FL_DW-1:0] KEY_DATA_A = 8'hAA;
  localparam logic [FL_DW-1:0] KEY_DATA_B = 8'h55;
  localparam logic [FL_DW-1:0] CODE_BACK_TO_READ = 8'hF0;

  typedef struct packed {
    logic [FL_AW-1:0] addr;
    logic [FL_DW-1:0] data;
  } wr_cycle_t;

  typedef enum logic [1:0] {PV_KEEP, PV_PASS, PV_RETRY, PV_FAIL} poll_verdict_e;

  // number of write cycles in the command phase of an opcode
  function automatic logic [2:0] cmd_len(input logic [2:0] opc);
    case (opc)
      OPC_PROG:      return 3'd4;
      OPC_ERASE:     return 3'd6;
      OPC_RST_FULL:  return 3'd3;
      OPC_RST_SHORT: return 3'd1;
      OPC_ID_MFR,
      OPC_ID_DEV:    return 3'd3;
      default:       return 3'd0;
    endcase
  endfunction

  function automatic logic [FL_AW-1:0] sector_base(input logic [FL_AW-1:0] a);
    return {a[FL_AW-1:14], 14'd0};
  endfunction

  // third-cycle code that names the command
  function automatic logic [FL_DW-1:0] cmd_code(input logic [2:0] opc);
    case (opc)
      OPC_PROG:     return 8'hA0;
      OPC_ERASE:    return 8'h80;
      OPC_RST_FULL: return CODE_BACK_TO_READ;
      default:      return 8'h90;
    endcase
  endfunction

  function automatic wr_cycle_t cmd_cycle(input logic [2:0] opc, input logic [2:0] idx,
                                          input logic [FL_AW-1:0] a, input logic [FL_DW-1:0] d);
    wr_cycle_t c;
    if (opc == OPC_RST_SHORT) begin
      c = '{addr: a, data: CODE_BACK_TO_READ};
    end else begin
      case (idx)
        3'd0:    c = '{addr: KEY_ADDR_A, data: KEY_DATA_A};
        3'd1:    c = '{addr: KEY_ADDR_B, data: KEY_DATA_B};
        3'd2:    c = '{addr: KEY_ADDR_A, data: cmd_code(opc)};
        3'd3:    c = (opc == OPC_PROG) ? '{addr: a, data: d}
                                       : '{addr: KEY_ADDR_A, data: KEY_DATA_A};
        3'd4:    c = '{addr: KEY_ADDR_B, data: KEY_DATA_B};
        default: c = '{addr: sector_base(a), data: 8'h30};
      endcase
    end
    return c;
  endfunction

  function automatic logic needs_poll(input logic [2:0] opc);
    return (opc == OPC_PROG) || (opc == OPC_ERASE);
  endfunction

  function automatic logic is_id(input logic [2:0] opc);
    return (opc == OPC_ID_MFR) || (opc == OPC_ID_DEV);
  endfunction

  function automatic logic poll_target(input logic [2:0] opc, input logic [FL_DW-1:0] d);
    return (opc == OPC_PROG) ? d[7] : 1'b1;
  endfunction

  function automatic logic [FL_DW-1:0] id_value(input logic [2:0] opc);
    return (opc == OPC_ID_DEV) ? 8'h20 : 8'h01;
  endfunction

  function automatic logic [FL_AW-1:0] id_addr(input logic [2:0] opc);
    return (opc == OPC_ID_DEV) ? 17'h00001 : 17'h00000;
  endfunction

  // decision on one status byte
  function automatic poll_verdict_e judge(input logic [FL_DW-1:0] st, input logic tgt,
                                          input logic second, input logic last);
    if (st[7] == tgt)  return PV_PASS;
    if (second)        return PV_FAIL;
    if (st[5])         return PV_RETRY;
    if (last)          return PV_FAIL;
    return PV_KEEP;
  endfunction

endpackage

// File: rtl/flash_bus_port.sv
module flash_bus_port
  import flash_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             cyc_we,
  input  logic [FL_AW-1:0] cyc_addr,
  input  logic [FL_DW-1:0] cyc_wdata,
  output logic             cyc_done,
  output logic [FL_DW-1:0] cyc_rdata,
  output logic             bus_req,
  output logic             bus_we,
  output logic [FL_AW-1:0] bus_addr,
  output logic [FL_DW-1:0] bus_wdata,
  input  logic             bus_ack,
  input  logic [FL_DW-1:0] bus_rdata
);

  logic             busy;
  logic             we_q;
  logic [FL_AW-1:0] addr_q;
  logic [FL_DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cyc_start && !busy) begin
      busy    <= 1'b1;
      we_q    <= cyc_we;
      addr_q  <= cyc_addr;
      wdata_q <= cyc_we ? cyc_wdata : '0;
    end else if (busy && bus_ack) begin
      busy <= 1'b0;
    end
  end

  assign cyc_done  = busy && bus_ack;
  assign cyc_rdata = bus_rdata;
  assign bus_req   = busy;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  // R11: fields held while waiting for the acknowledge
  a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R11: request drops for a cycle after each acknowledge
  a_r11_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !bus_req);

  // R11: the sequencer never launches over an outstanding cycle
  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> !busy);

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
  import flash_seq_pkg::*;
#(
  parameter int MAX_POLLS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic [FL_DW-1:0] status,
  input  logic             target,
  output poll_verdict_e    verdict
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] poll_cnt;
  logic             second_read;
  logic             budget_last;

  assign budget_last = (poll_cnt == LAST_IDX);
  assign verdict     = judge(status, target, second_read, budget_last);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      poll_cnt    <= '0;
      second_read <= 1'b0;
    end else if (sample) begin
      if (verdict == PV_RETRY) second_read <= 1'b1;
      if (verdict == PV_KEEP)  poll_cnt    <= poll_cnt + 1'b1;
    end
  end

  // R10: the plain-poll counter stays inside its budget
  a_r10_budget_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < CNT_W'(MAX_POLLS));

  // R8: a retry is granted once; the read after it always decides
  a_r8_one_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && verdict == PV_RETRY && !clear) |=> (second_read && (!sample || verdict != PV_RETRY)));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [FL_AW-1:0] op_addr,
  input  logic [FL_DW-1:0] op_data,
  output logic             op_ready,
  output logic             op_done,
  output logic             op_pass,
  output logic [FL_DW-1:0] op_result,
  output logic             cyc_start,
  output logic             cyc_we,
  output logic [FL_AW-1:0] cyc_addr,
  output logic [FL_DW-1:0] cyc_wdata,
  input  logic             cyc_done,
  input  logic [FL_DW-1:0] cyc_rdata,
  output logic             poll_clear,
  output logic             poll_sample,
  output logic             poll_target_bit,
  input  poll_verdict_e    poll_verdict
);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_IDRD, S_POLL, S_RECOV, S_FIN} seq_state_e;

  seq_state_e       st;
  logic             pend;
  logic [2:0]       idx;
  logic [2:0]       op_q;
  logic [FL_AW-1:0] addr_q;
  logic [FL_DW-1:0] data_q;
  logic [FL_DW-1:0] res_q;
  logic             pass_q;

  wr_cycle_t step_now;
  logic      wr_last;
  logic      bad_opcode;

  assign step_now   = cmd_cycle(op_q, idx, addr_q, data_q);
  assign wr_last    = (idx == cmd_len(op_q) - 3'd1);
  assign bad_opcode = (cmd_len(op_code) == 3'd0);

  assign op_ready        = (st == S_IDLE);
  assign op_done         = (st == S_FIN);
  assign op_pass         = pass_q;
  assign op_result       = res_q;
  assign poll_clear      = (st == S_IDLE);
  assign poll_sample     = (st == S_POLL) && cyc_done;
  assign poll_target_bit = poll_target(op_q, data_q);

  always_comb begin
    cyc_start = 1'b0;
    cyc_we    = 1'b0;
    cyc_addr  = addr_q;
    cyc_wdata = '0;
    case (st)
      S_WR: begin
        cyc_start = !pend;
        cyc_we    = 1'b1;
        cyc_addr  = step_now.addr;
        cyc_wdata = step_now.data;
      end
      S_IDRD: begin
        cyc_start = !pend;
        cyc_addr  = id_addr(op_q);
      end
      S_POLL: cyc_start = !pend;
      S_RECOV: begin
        cyc_start = !pend;
        cyc_we    = 1'b1;
        cyc_wdata = CODE_BACK_TO_READ;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= 1'b0;
      idx    <= '0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      res_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      if (cyc_start)      pend <= 1'b1;
      else if (cyc_done)  pend <= 1'b0;
      case (st)
        S_IDLE: if (op_valid) begin
          op_q   <= op_code;
          addr_q <= op_addr;
          data_q <= op_data;
          idx    <= '0;
          if (bad_opcode) begin
            res_q  <= '0;
            pass_q <= 1'b0;
            st     <= S_FIN;
          end else begin
            st <= S_WR;
          end
        end
        S_WR: if (cyc_done) begin
          if (wr_last) begin
            idx <= '0;
            if (needs_poll(op_q))  st <= S_POLL;
            else if (is_id(op_q))  st <= S_IDRD;
            else begin
              res_q  <= '0;
              pass_q <= 1'b1;
              st     <= S_FIN;
            end
          end else begin
            idx <= idx + 3'd1;
          end
        end
        S_IDRD: if (cyc_done) begin
          res_q  <= cyc_rdata;
          pass_q <= (cyc_rdata == id_value(op_q));
          st     <= S_RECOV;
        end
        S_POLL: if (cyc_done) begin
          res_q <= cyc_rdata;
          case (poll_verdict)
            PV_PASS: begin pass_q <= 1'b1; st <= S_FIN;   end
            PV_FAIL: begin pass_q <= 1'b0; st <= S_RECOV; end
            default: ;
          endcase
        end
        S_RECOV: if (cyc_done) st <= S_FIN;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: end pulse lasts one cycle and returns to idle
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (!op_done && op_ready));

  // R12: an unknown opcode finishes on the next cycle as a failure
  a_r12_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && op_valid && op_code[2:1] == 2'b11) |=> (op_done && !op_pass && op_result == 8'h00));

  // R2: the command phase never writes with address bit 16 set except to the caller's address
  a_r2_key_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && cyc_we && st == S_WR && idx < 3'd3 && op_q != OPC_RST_SHORT) |-> !cyc_addr[FL_AW-1]);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int MAX_POLLS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic [16:0] op_addr,
  input  logic [7:0]  op_data,
  output logic        op_ready,
  output logic        op_done,
  output logic        op_pass,
  output logic [7:0]  op_result,
  output logic        bus_req,
  output logic        bus_we,
  output logic [16:0] bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic        bus_ack,
  input  logic [7:0]  bus_rdata
);

  logic             cyc_start, cyc_we, cyc_done;
  logic [FL_AW-1:0] cyc_addr;
  logic [FL_DW-1:0] cyc_wdata, cyc_rdata;
  logic             poll_clear, poll_sample, poll_target_bit;
  poll_verdict_e    poll_verdict;

  flash_seq_ctrl u_ctrl (
    .clk, .rst_n,
    .op_valid, .op_code, .op_addr, .op_data,
    .op_ready, .op_done, .op_pass, .op_result,
    .cyc_start, .cyc_we, .cyc_addr, .cyc_wdata, .cyc_done, .cyc_rdata,
    .poll_clear, .poll_sample, .poll_target_bit, .poll_verdict
  );

  flash_poll_judge #(.MAX_POLLS(MAX_POLLS)) u_judge (
    .clk, .rst_n,
    .clear  (poll_clear),
    .sample (poll_sample),
    .status (cyc_rdata),
    .target (poll_target_bit),
    .verdict(poll_verdict)
  );

  flash_bus_port u_port (
    .clk, .rst_n,
    .cyc_start, .cyc_we, .cyc_addr, .cyc_wdata, .cyc_done, .cyc_rdata,
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata
  );

  // R11: no bus activity while the sequencer is idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !bus_req);

  // R13: quiet outputs in the first cycle after reset
  a_r13_after_reset: assert property (@(posedge clk)
    !rst_n |=> (op_ready && !op_done && !bus_req));

endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [16:0] op_addr = '0;
  logic [7:0]  op_data = '0;
  logic        op_ready, op_done, op_pass;
  logic [7:0]  op_result;
  logic        bus_req, bus_we;
  logic [16:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_ack = 1'b0;
  logic [7:0]  bus_rdata = '0;

  flash_cmd_seq uut (.*);

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  int stab_err = 0;
  int cycles = 0;
  bit seen_req = 0;
  logic [25:0] hold;
  logic [25:0] exp_q[$];
  logic [25:0] obs_q[$];
  logic [7:0]  rsp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // behavioural bus-cycle engine: acks after 'lat' waiting cycles
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      bus_ack = 1'b0; wcnt = 0; seen_req = 0;
    end else begin
      if (bus_req) begin
        if (seen_req && !bus_ack && {bus_we, bus_addr, bus_wdata} != hold) stab_err++;
        if (bus_ack) stab_err++;
        hold = {bus_we, bus_addr, bus_wdata};
        seen_req = 1;
      end else seen_req = 0;
      if (bus_req && !bus_ack) begin
        if (wcnt >= lat) begin
          bus_ack = 1'b1; wcnt = 0;
          obs_q.push_back({bus_we, bus_addr, bus_we ? bus_wdata : 8'h00});
          if (!bus_we) bus_rdata = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'hFF;
        end else wcnt++;
      end else bus_ack = 1'b0;
    end
  end

  task automatic ew(input logic [16:0] a, input logic [7:0] d); exp_q.push_back({1'b1, a, d}); endtask
  task automatic er(input logic [16:0] a); exp_q.push_back({1'b0, a, 8'h00}); endtask
  task automatic unlock(); ew(17'h05555, 8'hAA); ew(17'h02AAA, 8'h55); endtask

  task automatic run_op(input string tag, input logic [2:0] opc, input logic [16:0] a,
                        input logic [7:0] d, input bit xp, input logic [7:0] xr);
    int n;
    obs_q.delete();
    stab_err = 0;
    @(negedge clk);
    op_valid = 1'b1; op_code = opc; op_addr = a; op_data = d;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd7;
    chk(op_ready == 1'b0, {tag, " R1 ready low while busy"}, op_ready, 0);
    n = 0;
    while (!op_done && n < 3000) begin @(negedge clk); n++; end
    chk(op_done == 1'b1, {tag, " R1 op_done seen"}, op_done, 1);
    chk(op_pass == xp, {tag, " pass"}, op_pass, xp);
    chk(op_result == xr, {tag, " result"}, op_result, xr);
    @(negedge clk);
    chk(op_ready && !op_done, {tag, " R1 back to idle, pulse one cycle"}, {op_ready, op_done}, 2'b10);
    chk(obs_q.size() == exp_q.size(), {tag, " bus cycle count"}, obs_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      chk(obs_q[i] == exp_q[i], $sformatf("%s bus cycle %0d {we,addr,data}", tag, i), obs_q[i], exp_q[i]);
    chk(stab_err == 0, {tag, " R11 request held then dropped"}, stab_err, 0);
    exp_q.delete();
    rsp_q.delete();
    lat = (lat + 1) % 3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(op_ready && !op_done && !bus_req, "R13 reset state", {op_ready, op_done, bus_req}, 3'b100);

    // R2 R3 R7: program, two non-matching polls then done
    unlock(); ew(17'h05555, 8'hA0); ew(17'h01234, 8'h5A);
    er(17'h01234); er(17'h01234); er(17'h01234);
    rsp_q = '{8'hC0, 8'h80, 8'h5A};
    run_op("R3_R7 program", 3'd0, 17'h01234, 8'h5A, 1'b1, 8'h5A);

    // R4 R7: sector erase, address with low bits set
    unlock(); ew(17'h05555, 8'h80); ew(17'h05555, 8'hAA); ew(17'h02AAA, 8'h55); ew(17'h18000, 8'h30);
    er(17'h1ABCD); er(17'h1ABCD);
    rsp_q = '{8'h40, 8'h80};
    run_op("R4 erase", 3'd1, 17'h1ABCD, 8'h00, 1'b1, 8'h80);

    // R8: flag raised, re-read completes
    unlock(); ew(17'h05555, 8'hA0); ew(17'h0FF00, 8'hA5);
    er(17'h0FF00); er(17'h0FF00);
    rsp_q = '{8'h20, 8'hA5};
    run_op("R8 retry passes", 3'd0, 17'h0FF00, 8'hA5, 1'b1, 8'hA5);

    // R8 R9: flag raised, re-read still wrong -> fail and recovery write
    unlock(); ew(17'h05555, 8'hA0); ew(17'h00777, 8'h81);
    er(17'h00777); er(17'h00777); ew(17'h00777, 8'hF0);
    rsp_q = '{8'h20, 8'h20, 8'h80};
    run_op("R8_R9 retry fails", 3'd0, 17'h00777, 8'h81, 1'b0, 8'h20);

    // R10 R9: poll budget exhausted
    unlock(); ew(17'h05555, 8'h80); ew(17'h05555, 8'hAA); ew(17'h02AAA, 8'h55); ew(17'h04000, 8'h30);
    for (int i = 0; i < 16; i++) begin er(17'h04000); rsp_q.push_back(8'h00); end
    rsp_q.push_back(8'h80);
    ew(17'h04000, 8'hF0);
    run_op("R10 poll budget", 3'd1, 17'h04000, 8'h00, 1'b0, 8'h00);

    // R5 R2: full reset keeps bit 16 low
    unlock(); ew(17'h05555, 8'hF0);
    run_op("R5 full reset", 3'd2, 17'h1FFFF, 8'h00, 1'b1, 8'h00);

    // R5: short reset
    ew(17'h13333, 8'hF0);
    run_op("R5 short reset", 3'd3, 17'h13333, 8'h00, 1'b1, 8'h00);

    // R6: manufacturer code
    unlock(); ew(17'h05555, 8'h90); er(17'h00000); ew(17'h10000, 8'hF0);
    rsp_q = '{8'h01};
    run_op("R6 manufacturer", 3'd4, 17'h10000, 8'h00, 1'b1, 8'h01);

    // R6: device code, good and bad
    unlock(); ew(17'h05555, 8'h90); er(17'h00001); ew(17'h00000, 8'hF0);
    rsp_q = '{8'h20};
    run_op("R6 device good", 3'd5, 17'h00000, 8'h00, 1'b1, 8'h20);
    unlock(); ew(17'h05555, 8'h90); er(17'h00001); ew(17'h00000, 8'hF0);
    rsp_q = '{8'h21};
    run_op("R6 device bad", 3'd5, 17'h00000, 8'h00, 1'b0, 8'h21);

    // R12: unknown opcodes
    run_op("R12 opcode 6", 3'd6, 17'h00123, 8'h00, 1'b0, 8'h00);
    run_op("R12 opcode 7", 3'd7, 17'h00123, 8'h00, 1'b0, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired act=%0d exp=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule